// File: doc/BRIEF.md
# Hiccup Fault Protection Sequencer

This block supervises a power controller with several outputs. It takes raw comparator flags and decides when the outputs run, when they are inhibited, and when they are shut down for good. The flags are an over-voltage on the main output, an over-current from each switching channel, and an under-voltage from each linear channel. Every flag is asynchronous and is brought into the clock domain through a synchroniser chain.

The soft-start ramp is modelled as an up/down counter. Its value is exposed so that it can clamp the error amplifiers. An over-current inhibits every output at once. The ramp still finishes charging to its terminal value; only then is one strike counted, and the ramp is discharged back to zero before a fresh soft-start. On the third strike the block latches off and raises its fault output. An over-voltage bypasses this counting: it latches off immediately and turns on the low-side crowbar drive.

Linear under-voltage is blanked while the ramp is charging, so the linear outputs can come up without tripping. Only a power-on reset clears the strike count, the fault latch and the crowbar.

Top module: `hiccup_fault_seq`

## Requirements
- R1: A synchronised over-voltage flag forces the latched-off state on the next clock edge, from any state and with any strike count. The fault output is therefore high on the third rising edge after the flag is presented.
- R2: `crowbar_on` goes high together with an over-voltage latch-off and stays high until power-on reset, even after the flag is removed.
- R3: An over-current on either switching channel raises `inhibit_all` at once. The ramp keeps charging by one per clock until it reaches RAMP_MAX.
- R4: After an over-current strike that is not the last, `ss_discharge` is high and the ramp falls by one per clock to zero. The ramp then recharges from zero with `inhibit_all` low.
- R5: During soft-start the ramp rises by one per clock. At RAMP_MAX the block enters run with the ramp held at RAMP_MAX. The ramp never exceeds RAMP_MAX.
- R6: The STRIKES-th strike (default 3) counts once per completed ramp. It sets `fault_out`, `inhibit_all` and `ss_discharge` permanently. Later flags have no effect on these outputs until reset.
- R7: A linear under-voltage flag has no effect while the ramp is charging in soft-start: `inhibit_all` stays low and the ramp keeps rising.
- R8: In run, a linear under-voltage flag on either channel counts a strike and starts a discharge, exactly as an over-current does.
- R9: While `por_n` is low, `inhibit_all` is 1, and `ss_discharge`, `ss_level`, `crowbar_on` and `fault_out` are 0. Reset also clears the strike count, so one later strike does not latch off.
- R10: Every flag passes SYNC_STAGES (default 2) flops before it can act. A flag presented before an edge cannot change any output before the third following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| ov_main_a | input | 1 | Main-output over-voltage flag, asynchronous |
| oc_chan_a | input | N_SW | Switching-channel over-current flags, asynchronous |
| uv_lin_a | input | N_LIN | Linear-channel under-voltage flags, asynchronous |
| inhibit_all | output | 1 | Disables all outputs |
| ss_discharge | output | 1 | High while the ramp is being discharged |
| ss_level | output | RAMP_W | Soft-start ramp value, clamps the error amplifiers |
| crowbar_on | output | 1 | Forces the low-side switch on after an over-voltage |
| fault_out | output | 1 | Latched fault report, active high |

## Verification
The bench first tries a clean start. It then tries a single over-current pulse and a held over-current: the pulse must cause one hiccup and a return to run, while the held flag must run through three full ramps before latching off. Under-voltage is applied once during the ramp and once in run, which shows whether the blanking window is placed correctly. An over-voltage during soft-start is timed edge by edge, which separates the immediate latch-off path from the counted one and exposes the synchroniser delay. Power-on resets between the scenarios show whether the strike count and the crowbar are really cleared.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
   typedef enum logic [2:0] {
      ST_RESET,
      ST_SOFTSTART,
      ST_RUN,
      ST_OC_RAMP,
      ST_DISCHARGE,
      ST_LATCHED
   } seq_state_t;

   typedef enum logic [1:0] {
      RAMP_HOLD,
      RAMP_UP,
      RAMP_DOWN
   } ramp_cmd_t;
endpackage

// File: rtl/hfs_sync.sv
module hfs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hfs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hfs_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

   // R10: the output only ever shows what entered the chain earlier
   a_r10_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe[STAGES-2] != q) |=> (q == $past(pipe[STAGES-2])));
endmodule

// File: rtl/hfs_ramp.sv
module hfs_ramp
   import hfs_pkg::*;
#(
   parameter int RAMP_W   = 6,
   parameter int RAMP_MAX = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ramp_cmd_t         cmd,
   output logic [RAMP_W-1:0] level,
   output logic              at_top,
   output logic              at_zero
);
   localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_MAX);

   if (RAMP_MAX < 1 || RAMP_MAX >= (1 << RAMP_W)) begin : g_bad_max
      $error("hfs_ramp: RAMP_MAX must fit in RAMP_W bits and be non-zero");
   end

   assign at_top  = (level == TOP);
   assign at_zero = (level == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         case (cmd)
            RAMP_UP:   if (!at_top)  level <= level + 1'b1;
            RAMP_DOWN: if (!at_zero) level <= level - 1'b1;
            default:   level <= level;
         endcase
      end
   end

   a_r5_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= TOP);
   a_r5_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == RAMP_UP && !at_top) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/hfs_strike.sv
module hfs_strike #(
   parameter int STRIKES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bump,
   output logic last
);
   localparam int CW = $clog2(STRIKES + 1);
   localparam logic [CW-1:0] LAST_V = CW'(STRIKES - 1);

   if (STRIKES < 1) begin : g_bad_strikes
      $error("hfs_strike: STRIKES must be at least 1");
   end

   logic [CW-1:0] count;

   assign last = (count == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (bump && count <= LAST_V) count <= count + 1'b1;
   end

   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(STRIKES));
endmodule

// File: rtl/hiccup_fault_seq.sv
module hiccup_fault_seq
   import hfs_pkg::*;
#(
   parameter int N_SW        = 2,
   parameter int N_LIN       = 2,
   parameter int RAMP_W      = 6,
   parameter int RAMP_MAX    = 40,
   parameter int STRIKES     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ov_main_a,
   input  logic [N_SW-1:0]   oc_chan_a,
   input  logic [N_LIN-1:0]  uv_lin_a,
   output logic              inhibit_all,
   output logic              ss_discharge,
   output logic [RAMP_W-1:0] ss_level,
   output logic              crowbar_on,
   output logic              fault_out
);
   localparam int FLAG_W = 1 + N_SW + N_LIN;

   if (N_SW < 1 || N_LIN < 1) begin : g_bad_chan
      $error("hiccup_fault_seq: need at least one channel of each kind");
   end

   logic [FLAG_W-1:0] flags_s;
   logic ov_s, oc_s, uv_s;

   hfs_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(por_n),
      .d    ({ov_main_a, oc_chan_a, uv_lin_a}),
      .q    (flags_s)
   );

   assign ov_s = flags_s[FLAG_W-1];
   assign oc_s = |flags_s[N_LIN +: N_SW];
   assign uv_s = |flags_s[N_LIN-1:0];

   seq_state_t state, nxt;
   ramp_cmd_t  cmd;
   logic       ramp_top, ramp_zero, bump, last_strike, ov_seen;

   hfs_ramp #(.RAMP_W(RAMP_W), .RAMP_MAX(RAMP_MAX)) u_ramp (
      .clk    (clk),
      .rst_n  (por_n),
      .cmd    (cmd),
      .level  (ss_level),
      .at_top (ramp_top),
      .at_zero(ramp_zero)
   );

   hfs_strike #(.STRIKES(STRIKES)) u_strike (
      .clk  (clk),
      .rst_n(por_n),
      .bump (bump),
      .last (last_strike)
   );

   always_comb begin
      nxt  = state;
      bump = 1'b0;
      cmd  = RAMP_HOLD;
      case (state)
         ST_RESET: begin
            cmd = RAMP_DOWN;
            nxt = ST_SOFTSTART;
         end
         ST_SOFTSTART: begin
            cmd = RAMP_UP;
            if (oc_s)          nxt = ST_OC_RAMP;
            else if (ramp_top) nxt = ST_RUN;
         end
         ST_RUN: begin
            cmd = RAMP_HOLD;
            if (oc_s || uv_s) begin
               bump = 1'b1;
               nxt  = last_strike ? ST_LATCHED : ST_DISCHARGE;
            end
         end
         ST_OC_RAMP: begin
            cmd = RAMP_UP;
            if (ramp_top) begin
               bump = 1'b1;
               nxt  = last_strike ? ST_LATCHED : ST_DISCHARGE;
            end
         end
         ST_DISCHARGE: begin
            cmd = RAMP_DOWN;
            if (ramp_zero) nxt = ST_SOFTSTART;
         end
         default: begin
            cmd = RAMP_DOWN;
            nxt = ST_LATCHED;
         end
      endcase
      if (ov_s) nxt = ST_LATCHED;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state   <= ST_RESET;
         ov_seen <= 1'b0;
      end else begin
         state   <= nxt;
         ov_seen <= ov_seen | ov_s;
      end
   end

   assign inhibit_all  = !(state == ST_SOFTSTART || state == ST_RUN);
   assign ss_discharge = (state == ST_DISCHARGE) || (state == ST_LATCHED);
   assign fault_out    = (state == ST_LATCHED);
   assign crowbar_on   = ov_seen;

   a_r1_ov_latches: assert property (@(posedge clk) disable iff (!por_n)
      ov_s |=> fault_out);
   a_r2_crowbar_sticky: assert property (@(posedge clk) disable iff (!por_n)
      crowbar_on |=> crowbar_on);
   a_r3_inhibit_keeps_charging: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_OC_RAMP && !ramp_top && !ov_s) |=> (inhibit_all && ss_level == $past(ss_level) + 1'b1));
   a_r4_discharge_down: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_DISCHARGE && !ramp_zero) |=> (ss_level == $past(ss_level) - 1'b1));
   a_r6_latched_absorbing: assert property (@(posedge clk) disable iff (!por_n)
      fault_out |=> (fault_out && inhibit_all && ss_discharge));
   a_r7_uv_blanked: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_SOFTSTART && uv_s && !oc_s && !ov_s && !ramp_top) |=> (state == ST_SOFTSTART));
   a_r8_uv_in_run: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_RUN && uv_s) |=> (ss_discharge && inhibit_all));
endmodule

// File: tb/hiccup_fault_seq_test.sv
module hiccup_fault_seq_test;
   localparam int RW   = 5;
   localparam int RMAX = 20;
   localparam int NSTR = 3;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic ov_a = 1'b0;
   logic [1:0] oc_a = 2'b00;
   logic [1:0] uv_a = 2'b00;
   logic inhibit_all, ss_discharge, crowbar_on, fault_out;
   logic [RW-1:0] ss_level;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   hiccup_fault_seq #(.RAMP_W(RW), .RAMP_MAX(RMAX), .STRIKES(NSTR)) uut (
      .clk(clk), .por_n(por_n), .ov_main_a(ov_a), .oc_chan_a(oc_a),
      .uv_lin_a(uv_a), .inhibit_all(inhibit_all), .ss_discharge(ss_discharge),
      .ss_level(ss_level), .crowbar_on(crowbar_on), .fault_out(fault_out));

   // Behavioural reference: phase 0 idle-after-reset, 1 ramp up, 2 running,
   // 3 inhibited ramp up, 4 ramp down, 5 dead.
   int ph = 0, lvl = 0, hits = 0;
   bit crow = 0;
   bit [2:0] d1 = '0, d2 = '0;   // {ov, oc, uv} delay line

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ph = 0; lvl = 0; hits = 0; crow = 0; d1 = '0; d2 = '0;
      end else begin
         int np;
         np = ph;
         if (ph == 0) np = 1;
         else if (ph == 1) begin
            if (d2[1]) np = 3; else if (lvl == RMAX) np = 2;
         end else if ((ph == 2 && (d2[1] || d2[0])) || (ph == 3 && lvl == RMAX)) begin
            hits++;
            np = (hits >= NSTR) ? 5 : 4;
         end else if (ph == 4 && lvl == 0) np = 1;
         if (d2[2]) begin np = 5; crow = 1; end
         if ((ph == 1 || ph == 3) && lvl < RMAX) lvl++;
         else if ((ph == 0 || ph == 4 || ph == 5) && lvl > 0) lvl--;
         ph = np;
         d2 = d1;
         d1 = {ov_a, |oc_a, |uv_a};
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      chk(inhibit_all == !(ph == 1 || ph == 2), "R3 inhibit_all", inhibit_all, !(ph == 1 || ph == 2));
      chk(ss_discharge == (ph == 4 || ph == 5), "R4 ss_discharge", ss_discharge, (ph == 4 || ph == 5));
      chk(int'(ss_level) == lvl, "R5 ss_level", ss_level, lvl);
      chk(fault_out == (ph == 5), "R6 fault_out", fault_out, (ph == 5));
      chk(crowbar_on == crow, "R2 crowbar_on", crowbar_on, crow);
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic por_cycle();
      @(negedge clk); #1 por_n = 1'b0;
      wait_n(3);
      chk(inhibit_all && !ss_discharge && ss_level == 0 && !crowbar_on && !fault_out,
          "R9 reset outputs", {inhibit_all, ss_discharge, crowbar_on, fault_out}, 4'b1000);
      #1 por_n = 1'b1;
   endtask

   initial begin
      por_cycle();
      // R7: under-voltage while ramping is ignored
      wait_n(3); #1 uv_a = 2'b10;
      wait_n(8);
      chk(!inhibit_all && !fault_out, "R7 uv blanked", inhibit_all, 0);
      #1 uv_a = 2'b00;
      wait_n(20);
      chk(!inhibit_all && ss_level == RMAX, "R5 reached run", ss_level, RMAX);
      // R3/R4: single over-current pulse gives one hiccup
      #1 oc_a = 2'b10;
      wait_n(1); #1 oc_a = 2'b00;
      wait_n(3);
      chk(ss_discharge && inhibit_all, "R4 discharge after strike", ss_discharge, 1);
      wait_n(RMAX + RMAX + 6);
      chk(!inhibit_all && !fault_out && ss_level == RMAX, "R4 recovered to run", inhibit_all, 0);
      // R8: under-voltage in run counts a strike
      #1 uv_a = 2'b01;
      wait_n(1); #1 uv_a = 2'b00;
      wait_n(3);
      chk(ss_discharge && !fault_out, "R8 uv strike in run", ss_discharge, 1);
      wait_n(2 * RMAX + 6);
      // R9: reset clears strikes; one strike must not latch
      por_cycle();
      wait_n(RMAX + 4);
      #1 oc_a = 2'b01;
      wait_n(1); #1 oc_a = 2'b00;
      wait_n(4);
      chk(!fault_out, "R9 strikes cleared", fault_out, 0);
      wait_n(2 * RMAX + 6);
      por_cycle();
      // R3/R6: held over-current runs three ramps then latches
      wait_n(5); #1 oc_a = 2'b01;
      wait_n(4);
      chk(inhibit_all && !ss_discharge, "R3 inhibited while charging", inhibit_all, 1);
      wait_n(6 * RMAX + 20);
      chk(fault_out && inhibit_all, "R6 latched after three strikes", fault_out, 1);
      #1 oc_a = 2'b00;
      wait_n(2 * RMAX);
      chk(fault_out && !crowbar_on, "R6 latch holds, no crowbar", fault_out, 1);
      por_cycle();
      // R1/R10: over-voltage timing
      wait_n(8); #1 ov_a = 1'b1;
      wait_n(2);
      chk(!fault_out, "R10 not before third edge", fault_out, 0);
      wait_n(1);
      chk(fault_out, "R1 ov latches immediately", fault_out, 1);
      chk(crowbar_on, "R2 crowbar on", crowbar_on, 1);
      #1 ov_a = 1'b0;
      wait_n(30);
      chk(crowbar_on && fault_out, "R2 crowbar stays", crowbar_on, 1);
      por_cycle();
      chk(!crowbar_on, "R9 crowbar cleared", crowbar_on, 0);
      wait_n(5);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule